// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the stream of column addresses that an SDRAM controller drives to the device during a read or write burst, one address per clock. A request carries a starting column, a three-bit length code and an ordering bit. The ordering is either a sequential count that wraps inside an aligned block, or an interleaved order formed by XORing the start offset with the beat number. A full-page length walks the whole row and wraps at its end. It keeps going until a terminate input stops it.

The controller pulses `start_i` for one clock with the request fields valid. From the next clock the generator presents addresses on `col_o` with `valid_o` high, and marks the final beat of a fixed-length burst with `last_o`. A burst that cannot be honoured raises `err_o` for one clock. Two cases do this: a reserved length code, and the full-page plus interleaved combination. A reserved code starts nothing. The full-page interleaved request still runs, with sequential ordering. A new start always replaces a burst that is running.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `valid_o`, `last_o` and `err_o` are 0 and `col_o` is 0.
- R2: A start sampled at a clock edge with a fixed length code gives `valid_o` high from the next cycle for exactly BL consecutive cycles. The codes are 3'b000=1, 3'b001=2, 3'b010=4 and 3'b011=8. The first address equals the start column.
- R3: With sequential ordering (`intlv_i`=0), each address is the previous one plus one, taken modulo BL inside the aligned block. The column bits above log2(BL) keep the start column's value for the whole burst.
- R4: With interleaved ordering (`intlv_i`=1) and BL of 2, 4 or 8, beat k has the address whose low log2(BL) bits are the start's low bits XOR k. The upper bits are those of the start column.
- R5: With BL=1 exactly one address, equal to the start column, is produced, whatever the value of `intlv_i`.
- R6: With code 3'b111 (full page), the address steps by one per cycle through all 2^COL_W columns. It wraps from the top column to 0 and stays valid until terminated. `last_o` stays 0 in this mode.
- R7: `stop_i` high in a cycle with `valid_o` high ends the burst: `valid_o` is 0 in the next cycle. `stop_i` while idle has no effect.
- R8: A full-page request with `intlv_i`=1 raises `err_o` for exactly one cycle, the first beat. The burst runs with sequential ordering.
- R9: A start with a reserved length code (3'b100, 3'b101, 3'b110) starts no burst and ends any running one. `err_o` is high for one cycle after it.
- R10: A start during a running burst takes priority over `stop_i` and over the running burst. The new burst's first address appears in the next cycle.
- R11: `last_o` is high only together with `valid_o`, exactly on the final beat of a fixed-length burst that was not stopped early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle burst request |
| start_col_i | input | COL_W | Starting column of the burst |
| blen_i | input | 3 | Burst length code |
| intlv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A burst beat is presented |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | One-cycle flag for a rejected or downgraded request |

## Verification
The embedded assertions check the per-cycle rules on every clock. A load yields a valid first beat equal to the start column. A stop or a final beat closes the burst, and a reject leaves the generator idle. The beat counter steps by one. The block-select bits hold during a burst, and an error flag appears only after a start. Whole orderings can only be shown by the bench's reference model over complete scenarios. These include the 1-2-3-0 and 6-7-4-5-2-3-0-1 patterns, exact burst lengths, the full-page wrap from 511 to 0, restart priority and the reserved codes.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    // Burst length codes presented on blen_i
    typedef enum logic [2:0] {
        BLC_1    = 3'b000,
        BLC_2    = 3'b001,
        BLC_4    = 3'b010,
        BLC_8    = 3'b011,
        BLC_FULL = 3'b111
    } blen_code_e;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

    // Decoded request
    typedef struct packed {
        logic       accept;     // a burst will run
        logic       full_page;  // open-ended row walk
        order_e     order;      // effective ordering
        logic       flag_err;   // reserved code or unsupported combination
        logic [1:0] len_log2;   // log2 of fixed burst length
    } burst_cfg_t;

    function automatic burst_cfg_t decode_request(input logic [2:0] code, input logic intlv);
        burst_cfg_t c;
        c.accept    = 1'b1;
        c.full_page = 1'b0;
        c.order     = intlv ? ORD_INTLV : ORD_SEQ;
        c.flag_err  = 1'b0;
        c.len_log2  = 2'd0;
        case (blen_code_e'(code))
            BLC_1:    begin c.len_log2 = 2'd0; c.order = ORD_SEQ; end
            BLC_2:    c.len_log2 = 2'd1;
            BLC_4:    c.len_log2 = 2'd2;
            BLC_8:    c.len_log2 = 2'd3;
            BLC_FULL: begin
                c.full_page = 1'b1;
                c.flag_err  = intlv;
                c.order     = ORD_SEQ;
            end
            default:  begin
                c.accept   = 1'b0;
                c.flag_err = 1'b1;
                c.order    = ORD_SEQ;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [2:0]       blen_i,
    input  logic             intlv_i,
    output logic             accept_o,
    output logic             full_o,
    output logic             intlv_o,
    output logic             err_o,
    output logic [COL_W-1:0] mask_o
);
    localparam int FIX_BITS = 3;   // widest fixed block is 8 columns

    burst_cfg_t cfg;

    always_comb cfg = decode_request(blen_i, intlv_i);

    assign accept_o = cfg.accept;
    assign full_o   = cfg.full_page;
    assign intlv_o  = (cfg.order == ORD_INTLV);
    assign err_o    = cfg.flag_err;

    // Offset mask: low bits that move inside the block
    for (genvar g = 0; g < COL_W; g++) begin : g_mask
        if (g < FIX_BITS) begin : g_low
            assign mask_o[g] = cfg.full_page | (int'(cfg.len_log2) > g);
        end else begin : g_high
            assign mask_o[g] = cfg.full_page;
        end
    end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             reject_i,
    input  logic             stop_i,
    input  logic             full_i,
    input  logic [COL_W-1:0] mask_i,
    output logic             valid_o,
    output logic             last_o,
    output logic [COL_W-1:0] beat_o
);
    logic             valid_r;
    logic             full_r;
    logic [COL_W-1:0] mask_r;
    logic [COL_W-1:0] beat_r;

    assign last_o  = valid_r & ~full_r & (beat_r == mask_r);
    assign valid_o = valid_r;
    assign beat_o  = beat_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_r <= 1'b0;
            full_r  <= 1'b0;
            mask_r  <= '0;
            beat_r  <= '0;
        end else if (load_i) begin
            valid_r <= 1'b1;
            full_r  <= full_i;
            mask_r  <= mask_i;
            beat_r  <= '0;
        end else if (reject_i) begin
            valid_r <= 1'b0;
        end else if (valid_r) begin
            if (stop_i || last_o) begin
                valid_r <= 1'b0;
            end else begin
                beat_r <= beat_r + COL_W'(1);
            end
        end
    end

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);                                                  // R11
    AST_LOAD_OPENS: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (valid_o && beat_o == '0));                                // R10
    AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (valid_o && stop_i && !load_i) |=> !valid_o);                         // R7
    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (last_o && !load_i) |=> !valid_o);                                    // R2
    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (reject_i && !load_i) |=> !valid_o);                                  // R9
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !stop_i && !load_i && !reject_i)
            |=> (valid_o && beat_o == COL_W'($past(beat_o) + COL_W'(1))));    // R6

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             intlv_i,
    input  logic             valid_i,
    input  logic [COL_W-1:0] beat_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] start_r;
    logic [COL_W-1:0] mask_r;
    logic             intlv_r;
    logic [COL_W-1:0] seq_off;
    logic [COL_W-1:0] xor_off;
    logic [COL_W-1:0] offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_r <= '0;
            mask_r  <= '0;
            intlv_r <= 1'b0;
        end else if (load_i) begin
            start_r <= start_col_i;
            mask_r  <= mask_i;
            intlv_r <= intlv_i;
        end
    end

    always_comb begin
        seq_off = start_r + beat_i;
        xor_off = start_r ^ beat_i;
        offset  = intlv_r ? xor_off : seq_off;
        col_o   = (start_r & ~mask_r) | (offset & mask_r);
    end

    AST_FIRST_IS_START: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (col_o == $past(start_col_i)));                            // R2
    AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !load_i) |=> (!valid_i ||
            ((col_o & ~mask_r) == ($past(col_o) & ~mask_r))));                // R3

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_i,
    input  logic             intlv_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    logic             dec_accept;
    logic             dec_full;
    logic             dec_intlv;
    logic             dec_err;
    logic [COL_W-1:0] dec_mask;
    logic             load;
    logic             reject;
    logic             err_r;
    logic [COL_W-1:0] beat;

    burst_cfg_decode #(.COL_W(COL_W)) i_decode (
        .blen_i   (blen_i),
        .intlv_i  (intlv_i),
        .accept_o (dec_accept),
        .full_o   (dec_full),
        .intlv_o  (dec_intlv),
        .err_o    (dec_err),
        .mask_o   (dec_mask)
    );

    assign load   = start_i &  dec_accept;
    assign reject = start_i & ~dec_accept;

    always_ff @(posedge clk) begin
        if (rst) err_r <= 1'b0;
        else     err_r <= start_i & dec_err;
    end
    assign err_o = err_r;

    burst_beat_ctrl #(.COL_W(COL_W)) i_beat (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .reject_i (reject),
        .stop_i   (stop_i),
        .full_i   (dec_full),
        .mask_i   (dec_mask),
        .valid_o  (valid_o),
        .last_o   (last_o),
        .beat_o   (beat)
    );

    burst_addr_map #(.COL_W(COL_W)) i_addr (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .start_col_i (start_col_i),
        .mask_i      (dec_mask),
        .intlv_i     (dec_intlv),
        .valid_i     (valid_o),
        .beat_i      (beat),
        .col_o       (col_o)
    );

    AST_ERR_FROM_START: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(start_i));                                            // R8
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (err_o && !$past(start_i, 1)) |-> 1'b0);                              // R9

endmodule

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 9;
    localparam int PAGE       = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       blen_i = 3'b000;
    logic             intlv_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;
    logic             err_o;

    int    n_run  = 0;
    int    n_fail = 0;
    bit    chk_en = 1'b0;
    bit    done   = 1'b0;
    string cur_req = "R2";

    // reference model state
    bit m_valid = 0, m_err = 0, m_intlv = 0;
    int m_start = 0, m_len = 0, m_k = 0;   // m_len 0 means full page

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .intlv_i(intlv_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    function automatic int exp_col();
        int blk, base, off;
        blk  = (m_len == 0) ? PAGE : m_len;
        base = m_start - (m_start % blk);
        if (m_intlv) off = (m_start % blk) ^ m_k;
        else         off = ((m_start % blk) + m_k) % blk;
        return base + off;
    endfunction

    function automatic bit exp_last();
        return m_valid && m_len != 0 && m_k == m_len - 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_valid = 0; m_err = 0; m_k = 0;
        end else begin
            bit was_last;
            was_last = exp_last();
            m_err = 0;
            if (start_i) begin
                int len;
                bit ok;
                ok = 1;
                case (blen_i)
                    3'b000: len = 1;
                    3'b001: len = 2;
                    3'b010: len = 4;
                    3'b011: len = 8;
                    3'b111: len = 0;
                    default: begin len = 1; ok = 0; end
                endcase
                if (!ok) begin
                    m_valid = 0; m_err = 1;
                end else begin
                    m_valid = 1; m_k = 0; m_start = int'(start_col_i); m_len = len;
                    m_intlv = (len > 1) && intlv_i;
                    m_err   = (len == 0) && intlv_i;
                end
            end else if (m_valid) begin
                if (stop_i || was_last) m_valid = 0;
                else m_k = (m_k + 1) % PAGE;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            check(cur_req, "valid", int'(valid_o), int'(m_valid));
            check("R11", "last", int'(last_o), int'(exp_last()));
            check(m_len == 0 ? "R8" : "R9", "err", int'(err_o), int'(m_err));
            if (m_valid) check(cur_req, "col", int'(col_o), exp_col());
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic go(string req, logic [2:0] code, logic il, int col);
        cur_req     = req;
        start_i     = 1'b1;
        blen_i      = code;
        intlv_i     = il;
        start_col_i = COL_W'(col);
        tick(1);
        start_i = 1'b0;
    endtask

    task automatic stop_pulse();
        stop_i = 1'b1;
        tick(1);
        stop_i = 1'b0;
    endtask

    initial begin
        tick(2);
        // R1 reset state
        check("R1", "valid", int'(valid_o), 0);
        check("R1", "last",  int'(last_o), 0);
        check("R1", "err",   int'(err_o), 0);
        check("R1", "col",   int'(col_o), 0);
        rst = 1'b0;
        tick(1);
        check("R1", "col after reset", int'(col_o), 0);
        chk_en = 1'b1;

        go("R3", 3'b010, 1'b0, 1);       tick(6);   // 1-2-3-0
        go("R3", 3'b011, 1'b0, 5);       tick(10);  // 5-6-7-0-1-2-3-4
        go("R3", 3'b011, 1'b0, 9'h1A5);  tick(10);  // upper bits kept
        go("R2", 3'b001, 1'b0, 9'h0FF);  tick(4);
        go("R4", 3'b010, 1'b1, 1);       tick(6);   // 1-0-3-2
        go("R4", 3'b011, 1'b1, 6);       tick(10);  // 6-7-4-5-2-3-0-1
        go("R4", 3'b001, 1'b1, 9'h133);  tick(4);
        go("R5", 3'b000, 1'b1, 9'h07B);  tick(3);
        go("R5", 3'b000, 1'b0, 9'h1FF);  tick(3);
        go("R6", 3'b111, 1'b0, 508);     tick(9);   // wraps 511 -> 0
        cur_req = "R7"; stop_pulse();    tick(3);
        cur_req = "R7"; stop_pulse();    tick(2);   // idle stop
        go("R7", 3'b011, 1'b0, 2);       tick(3);
        stop_pulse();                    tick(3);
        go("R8", 3'b111, 1'b1, 6);       tick(12);
        cur_req = "R8"; stop_pulse();    tick(2);
        go("R9", 3'b100, 1'b0, 3);       tick(3);
        go("R9", 3'b101, 1'b1, 3);       tick(1);
        go("R9", 3'b110, 1'b0, 3);       tick(3);
        go("R9", 3'b011, 1'b0, 0);       tick(2);
        go("R9", 3'b101, 1'b0, 0);       tick(3);   // reject ends burst
        go("R10", 3'b011, 1'b0, 0);      tick(3);
        stop_i = 1'b1;
        go("R10", 3'b010, 1'b1, 9'h0E2);            // start beats stop
        stop_i = 1'b0;                   tick(6);
        go("R10", 3'b111, 1'b0, 100);    tick(4);
        go("R10", 3'b001, 1'b0, 9'h011); tick(4);
        // whole page run with wrap back to the start column
        go("R6", 3'b111, 1'b0, 17);      tick(PAGE + 3);
        cur_req = "R6"; stop_pulse();    tick(3);

        chk_en = 1'b0;
        done   = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule